// File: doc/BRIEF.md
# Word-Addressed Serial Port Register Front-End

This block is the register side of a simple serial port. It sits as a slave on a 32-bit memory-mapped bus and connects to a byte-wide receive stream and a byte-wide transmit stream. Baud timing and serialization are handled elsewhere. The block holds at most one received byte. A flag marks that byte as waiting, and the receive stream's ready signal is the inverse of that flag. When the CPU reads the data word, the byte is taken and the flag clears. Every word the CPU writes to the transmit offset leaves as one byte on the transmit stream in the next cycle.

Every bus access completes in the cycle it is presented, with no wait states. Read data is valid combinationally while `bus_sel_i` is high. Side effects such as clearing the flag, storing a byte or launching a transmit byte take effect at the closing clock edge. The window is 0x18 bytes long and is decoded as words: byte address bits [1:0] are ignored. Only full-word accesses, with all four byte enables set, are honoured.

Top module: `uart_fe_regs`

## Requirements
- R1: After reset the held byte is 0x00, the status word reads 0x0000_0002, `rx_ready_o` is 1 and `tx_valid_o` is 0.
- R2: The status word (byte offset 0x14) carries the receive-ready flag in bit 0 and a transmit-ready bit in bit 1, which always reads 1. Bits [31:2] read 0.
- R3: A read of the receive word (byte offset 0x04) returns the held byte in bits [7:0], with zeros above. From the next cycle the receive-ready flag is clear.
- R4: A receive byte is accepted only in a cycle where `rx_valid_i` is high and the flag is clear. Accepting it stores the byte and sets the flag. `rx_ready_o` always equals the inverse of the flag, and a byte offered while the flag is set leaves the held byte unchanged.
- R5: If a receive read and an offered byte fall in the same cycle while the flag is set, the read returns the old byte, the flag clears and the new byte is dropped. If the flag was clear in that cycle, the read returns the stale held byte, the new byte is stored and the flag sets.
- R6: A write to the status word changes no state.
- R7: A write to the transmit word (byte offset 0x00) raises `tx_valid_o` for exactly the next cycle, with `tx_data_o` equal to write data bits [7:0].
- R8: Registers are selected by byte address bits [ADDR_W-1:2]. Bits [1:0] have no effect.
- R9: A read at an unmapped offset returns zero and has no side effect. This covers the words at 0x08, 0x0C and 0x10, any address at 0x18 or above, and reads of the transmit word. A write at an unmapped offset is discarded.
- R10: An access whose byte enables are not all set reads zero, changes no state and produces no transmit byte.
- R11: A read of the status word has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access present this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address within the block |
| bus_be_i | input | 4 | Byte enables, all four needed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Holding register empty |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Transmit byte |

## Verification
The only state is the flag and the held byte. A wrong flag shows at once on `rx_ready_o` and in the next status read. A corrupted byte only shows when the receive word is read, so stimulus reads that word often, including in cycles that collide with an offered byte. A decode slip appears in the same cycle as a nonzero read of an unmapped or partial access, or as a missing or spurious `tx_valid_o` pulse one cycle after a write. The random mix holds the offered stream active across long runs so that stored-versus-dropped bytes are compared against a bench model on every access.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BE_W      = BUS_W / 8;
  localparam int unsigned WIN_BYTES = 24;
  // word indices, byte address >> 2
  localparam int unsigned TX_WORD   = 0;
  localparam int unsigned RX_WORD   = 1;
  localparam int unsigned ST_WORD   = 5;
  // status bit positions
  localparam int unsigned ST_RX_BIT = 0;
  localparam int unsigned ST_TX_BIT = 1;

  typedef struct packed {
    logic rd_rx;
    logic rd_st;
    logic wr_tx;
    logic wr_st;
    logic valid;
  } fe_strobe_t;
endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] addr_i,
  output fe_strobe_t        strb_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              in_win;
  logic              full_word;
  logic              unused_lsb;

  assign word       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign in_win     = addr_i < ADDR_W'(WIN_BYTES);
  assign full_word  = &be_i;

  always_comb begin
    strb_o       = '0;
    strb_o.valid = sel_i && in_win && full_word;
    if (strb_o.valid) begin
      strb_o.rd_rx = !we_i && (word == WORD_W'(RX_WORD));
      strb_o.rd_st = !we_i && (word == WORD_W'(ST_WORD));
      strb_o.wr_tx =  we_i && (word == WORD_W'(TX_WORD));
      strb_o.wr_st =  we_i && (word == WORD_W'(ST_WORD));
    end
  end
endmodule

// File: rtl/uart_fe_rx_hold.sv
module uart_fe_rx_hold
  import uart_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o
);
  logic              full_q;
  logic [BYTE_W-1:0] data_q;
  logic              push;

  assign rx_ready_o = !full_q;
  assign push       = rx_valid_i && rx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (push) begin
        full_q <= 1'b1;
        data_q <= rx_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> $stable(data_q));
  // R4
  push_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !full_q) |=> (full_q && data_q == $past(rx_data_i)));
  // R3
  take_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && full_q) |=> !full_q);
endmodule

// File: rtl/uart_fe_tx_push.sv
module uart_fe_tx_push
  import uart_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic              vld_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q <= wr_i;
      if (wr_i) byte_q <= byte_i;
    end
  end

  assign tx_valid_o = vld_q;
  assign tx_data_o  = byte_q;

  // R7
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (tx_valid_o && tx_data_o == $past(byte_i)));
  // R7
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !tx_valid_o);
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o
);
  fe_strobe_t        strb;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_full;
  logic [BUS_W-1:0]  st_word;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[BUS_W-1:BYTE_W];

  uart_fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel_i),
    .we_i   (bus_we_i),
    .be_i   (bus_be_i),
    .addr_i (bus_addr_i),
    .strb_o (strb)
  );

  uart_fe_rx_hold u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .take_i     (strb.rd_rx),
    .data_o     (rx_byte),
    .full_o     (rx_full)
  );

  uart_fe_tx_push u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (strb.wr_tx),
    .byte_i     (bus_wdata_i[BYTE_W-1:0]),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  // status word: flags at fixed bits, rest zero
  generate
    for (genvar b = 0; b < BUS_W; b++) begin : g_st
      if (b == ST_RX_BIT) begin : g_rx
        assign st_word[b] = rx_full;
      end else if (b == ST_TX_BIT) begin : g_tx
        assign st_word[b] = 1'b1;
      end else begin : g_zero
        assign st_word[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata_o = '0;
    if (strb.rd_rx)      bus_rdata_o = {{(BUS_W-BYTE_W){1'b0}}, rx_byte};
    else if (strb.rd_st) bus_rdata_o = st_word;
  end

  // R2
  st_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.rd_st |-> (bus_rdata_o[31:2] == '0 && bus_rdata_o[1] && bus_rdata_o[0] == !rx_ready_o));
  // R6
  st_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.wr_st && !rx_valid_i) |=> ($stable(rx_full) && $stable(rx_byte) && !tx_valid_o));
  // R11
  st_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.rd_st && !(rx_valid_i && rx_ready_o)) |=> $stable(rx_full));
  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i >= ADDR_W'(WIN_BYTES)) |-> bus_rdata_o == '0);
  // R10
  partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_be_i != 4'hF) |-> (bus_rdata_o == '0 && !strb.rd_rx && !strb.wr_tx));
endmodule

// File: tb/tb_uart_fe_regs.sv
module tb_uart_fe_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic       m_full = 1'b0;
  logic [7:0] m_data = 8'h00;

  always #10 clk_i = !clk_i;

  uart_fe_regs dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic we, input logic [7:0] addr, input logic [3:0] be);
    logic [31:0] r;
    r = '0;
    if (!we && be == 4'hF && addr < 8'h18) begin
      if ((addr >> 2) == 1) r = {24'h0, m_data};
      else if ((addr >> 2) == 5) r = {30'h0, 1'b1, m_full};
    end
    return r;
  endfunction

  function automatic string req_of(input logic we, input logic [7:0] addr, input logic [3:0] be);
    if (be != 4'hF) return "R10";
    if (addr >= 8'h18) return "R9";
    case (addr >> 2)
      0: return we ? "R7" : "R9";
      1: return we ? "R9" : "R3";
      5: return we ? "R6" : "R2";
      default: return "R9";
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic acc(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                     input logic [3:0] be, input logic rxv, input logic [7:0] rxd, input string req);
    logic ok, push, rd, etx;
    ok = (be == 4'hF) && (addr < 8'h18);
    bus_sel_i = 1'b1; bus_we_i = we; bus_addr_i = addr; bus_be_i = be; bus_wdata_i = wd;
    rx_valid_i = rxv; rx_data_i = rxd;
    #5;
    chk(req, "rdata", bus_rdata_o, exp_rd(we, addr, be));
    chk("R4", "rx_ready", {31'h0, rx_ready_o}, {31'h0, !m_full});
    push = rxv && !m_full;
    rd   = ok && !we && ((addr >> 2) == 1);
    etx  = ok && we && ((addr >> 2) == 0);
    @(posedge clk_i);
    @(negedge clk_i);
    if (push) begin m_full = 1'b1; m_data = rxd; end
    else if (rd) m_full = 1'b0;
    bus_sel_i = 1'b0; rx_valid_i = 1'b0;
    chk(etx ? "R7" : req, "tx_valid", {31'h0, tx_valid_o}, {31'h0, etx});
    if (etx) chk("R7", "tx_data", {24'h0, tx_data_o}, {24'h0, wd[7:0]});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk_i);
    // R1: outputs during reset and after release
    chk("R1", "rx_ready rst", {31'h0, rx_ready_o}, 32'h1);
    chk("R1", "tx_valid rst", {31'h0, tx_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R1");
    acc(0, 8'h04, 0, 4'hF, 0, 0, "R1");
    // R4 / R2 / R11: accept, then refuse while full
    acc(0, 8'h14, 0, 4'hF, 1, 8'hA5, "R11");
    acc(0, 8'h14, 0, 4'hF, 1, 8'h3C, "R4");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R2");
    acc(0, 8'h04, 0, 4'hF, 0, 0, "R3");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R3");
    // R5: collision with flag set, then with flag clear
    acc(0, 8'h14, 0, 4'hF, 1, 8'h11, "R5");
    acc(0, 8'h04, 0, 4'hF, 1, 8'h22, "R5");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R5");
    acc(0, 8'h04, 0, 4'hF, 1, 8'h33, "R5");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R5");
    // R6: status writes with flag set
    acc(1, 8'h14, 32'hFFFF_FFFF, 4'hF, 0, 0, "R6");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R6");
    // R8: low address bits ignored
    acc(0, 8'h07, 0, 4'hF, 0, 0, "R8");
    acc(0, 8'h17, 0, 4'hF, 0, 0, "R8");
    acc(1, 8'h03, 32'hCAFE_BE5A, 4'hF, 0, 0, "R8");
    // R6 with flag clear
    acc(1, 8'h14, 32'h0000_0001, 4'hF, 0, 0, "R6");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R6");
    // R7: back-to-back transmit writes
    acc(1, 8'h00, 32'h1234_5678, 4'hF, 0, 0, "R7");
    acc(1, 8'h00, 32'h0000_0000, 4'hF, 0, 0, "R7");
    acc(0, 8'h14, 0, 4'hF, 1, 8'h9E, "R7");
    // R9: unmapped reads and writes, flag set
    acc(0, 8'h08, 0, 4'hF, 0, 0, "R9");
    acc(0, 8'h0C, 0, 4'hF, 0, 0, "R9");
    acc(0, 8'h10, 0, 4'hF, 0, 0, "R9");
    acc(0, 8'h00, 0, 4'hF, 0, 0, "R9");
    acc(0, 8'h18, 0, 4'hF, 0, 0, "R9");
    acc(0, 8'hFC, 0, 4'hF, 0, 0, "R9");
    acc(1, 8'h18, 32'h55, 4'hF, 0, 0, "R9");
    acc(1, 8'h04, 32'h66, 4'hF, 0, 0, "R9");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R9");
    // R10: partial enables
    acc(1, 8'h00, 32'h77, 4'h1, 0, 0, "R10");
    acc(0, 8'h04, 0, 4'h7, 0, 0, "R10");
    acc(0, 8'h14, 0, 4'hE, 0, 0, "R10");
    acc(0, 8'h14, 0, 4'hF, 0, 0, "R10");
    acc(0, 8'h04, 0, 4'hF, 0, 0, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [7:0] a;
      logic [3:0] be;
      int k;
      we = ($urandom % 3) == 0;
      k  = $urandom % 6;
      case (k)
        0: a = 8'h00 | 8'($urandom % 4);
        1, 2: a = 8'h04 | 8'($urandom % 4);
        3: a = 8'h14;
        default: a = 8'($urandom % 64);
      endcase
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      acc(we, a, $urandom, be, ($urandom % 2) == 0, 8'($urandom), req_of(we, a, be));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule